// File: doc/BRIEF.md
# Two-Wire Write-Only Bus Receiver

This block is the receive side of a two-wire serial bus slave that only ever accepts writes. It samples the clock and data lines with a faster system clock and finds START and STOP conditions on the bus. It compares the first byte of each transfer against its own 7-bit device address. The four upper address bits are a parameter and the three lower bits come from strap inputs. On a match it acknowledges the byte by pulling the data line low through an open-drain enable.

After a matching write address the block takes up to three bytes in a fixed order: a command byte, then the low data byte, then the high data byte. Each accepted byte is announced to downstream logic with a single-cycle strobe. The command is delivered as soon as it is acknowledged. The two data bytes are only delivered together, once the high byte has been acknowledged, so a transfer that is cut short never hands out half a data word. A second, shared address (all ones followed by a zero) acts as a broadcast quick command: the bit in the read/write position is passed on as a flag, and nothing follows it. STOP and repeated START are also reported as strobes, so a register stage behind this block can decide when to commit the values.

Top module: `i2c_wr_slave`

## Requirements
- R1: While rst_n is low and in the first cycle after reset, sda_oe is 0, every strobe is 0, and cmd_q, lo_q, hi_q and quick_flag are 0.
- R2: For an accepted byte, sda_oe is 1 for the whole high phase of the ninth (acknowledge) SCL clock. sda_oe changes only while the synchronised SCL is low, or in response to a START or STOP.
- R3: An address byte whose upper seven bits (MSB first) equal {ADDR_HI = 4'b0100, addr_sel[2:0]} and whose bit 0 (R/W) is 0 is acknowledged. Any other address that is not the broadcast address is not acknowledged, and the block ignores the bus until the next START.
- R4: The first byte after an acknowledged write address is the command byte. It is always acknowledged, and cmd_stb pulses with cmd_q equal to that byte at the rising SCL of its acknowledge clock. It stays delivered if the transfer ends right after it.
- R5: The second and third bytes are acknowledged. lo_stb and hi_stb pulse in the same cycle, at the rising SCL of the third byte's acknowledge clock, with lo_q equal to the second byte and hi_q equal to the third.
- R6: A START or STOP before the command byte's acknowledge clock produces no cmd_stb. A START or STOP before the high data byte's acknowledge clock produces no lo_stb and no hi_stb.
- R7: The broadcast address 7'b1111110 is acknowledged whatever its bit 0 is. quick_stb pulses with quick_flag equal to bit 0, and any later byte in that transfer is not acknowledged.
- R8: A read request (bit 0 = 1) to the block's own address is not acknowledged. A fourth or later byte after the block's own write address is not acknowledged and produces no strobe.
- R9: stop_stb pulses once for every STOP, and sda_oe is 0 in that cycle. rstart_stb pulses for a START that arrives while an earlier START has not yet been closed by a STOP. It does not pulse for a START on an idle bus.
- R10: Every strobe lasts exactly one system clock. cmd_stb, hi_stb, quick_stb, stop_stb and rstart_stb are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 3 | Strap pins forming the low address bits |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| cmd_stb | output | 1 | Command byte accepted |
| cmd_q | output | 8 | Last accepted command byte |
| lo_stb | output | 1 | Low data byte delivered |
| lo_q | output | 8 | Last delivered low data byte |
| hi_stb | output | 1 | High data byte delivered |
| hi_q | output | 8 | Last delivered high data byte |
| quick_stb | output | 1 | Broadcast quick command received |
| quick_flag | output | 1 | Flag bit of the last broadcast |
| stop_stb | output | 1 | STOP seen on the bus |
| rstart_stb | output | 1 | Repeated START seen on the bus |

## Verification
The assertions check on every cycle that no strobe is longer than one clock and that the strobes are mutually exclusive. They also check that the open-drain enable only moves while the synchronised clock is low or on a bus condition, and that it is released at every STOP. Whether a byte is acknowledged, which value reaches cmd_q, lo_q and hi_q, and whether a cut-short transfer drops its data bytes but keeps its command depend on the whole byte sequence. Only the bench scenarios can show these. They use directed transfers (full, command-only, cut mid-byte, cut after the low byte, foreign address, read, broadcast, overlong) mixed with random transfers whose outcome a bench model predicts.

// File: rtl/i2c_wr_pkg.sv
// Package: shared types and constants of the write-only two-wire receiver.
// Assumes: bytes on the bus are 8 bits, MSB first.
package i2c_wr_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // ignoring bus until START
        ST_ADDR,   // receiving the address byte
        ST_CMD,    // receiving the command byte
        ST_LO,     // receiving the low data byte
        ST_HI      // receiving the high data byte
    } frame_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-flop synchroniser for one asynchronous bus line.
// Assumes: the line idles at RST_VAL; output lags input by STAGES clocks.
module i2c_line_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
// Module: finds SCL edges and START/STOP conditions on synchronised lines.
// Assumes: inputs are already synchronised to clk; both lines idle high.
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d;
    logic sda_d;

    // Keep the previous sample of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_frame_fsm.sv
// Module: byte framing, address match, acknowledge and strobe generation.
// Assumes: edge/condition inputs are single-cycle pulses; the byte order
// after the address is command, low data, high data.
module i2c_frame_fsm
    import i2c_wr_pkg::*;
#(
    parameter int unsigned         ADDR_HI_W  = 4,
    parameter int unsigned         SEL_W      = 3,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI   = 4'b0100,
    parameter logic [ADDR_HI_W+SEL_W-1:0] QUICK_ADDR = 7'b1111110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  addr_sel,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              cmd_stb,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              lo_stb,
    output logic [BYTE_W-1:0] lo_q,
    output logic              hi_stb,
    output logic [BYTE_W-1:0] hi_q,
    output logic              quick_stb,
    output logic              quick_flag,
    output logic              stop_stb,
    output logic              rstart_stb
);
    localparam int unsigned DEV_W = ADDR_HI_W + SEL_W;
    localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    frame_st_t         state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] lo_hold;
    logic              in_ack;
    logic              bus_active;

    logic              own_w;
    logic              is_quick;
    logic              accept;
    frame_st_t         next_st;

    // Decide whether the byte just shifted in is to be acknowledged.
    always_comb begin
        own_w    = (shreg[BYTE_W-1:1] == DEV_W'({ADDR_HI, addr_sel})) && !shreg[0];
        is_quick = (shreg[BYTE_W-1:1] == QUICK_ADDR);
        unique case (state)
            ST_ADDR:                 accept = own_w || is_quick;
            ST_CMD, ST_LO, ST_HI:    accept = 1'b1;
            default:                 accept = 1'b0;
        endcase
    end

    // Successor state once the acknowledge clock ends.
    always_comb begin
        unique case (state)
            ST_ADDR: next_st = is_quick ? ST_IDLE : ST_CMD;
            ST_CMD:  next_st = ST_LO;
            ST_LO:   next_st = ST_HI;
            default: next_st = ST_IDLE;
        endcase
    end

    // Main sequencer: bus conditions, bit shifting, acknowledge and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            lo_hold    <= '0;
            in_ack     <= 1'b0;
            bus_active <= 1'b0;
            sda_oe     <= 1'b0;
            cmd_stb    <= 1'b0;
            cmd_q      <= '0;
            lo_stb     <= 1'b0;
            lo_q       <= '0;
            hi_stb     <= 1'b0;
            hi_q       <= '0;
            quick_stb  <= 1'b0;
            quick_flag <= 1'b0;
            stop_stb   <= 1'b0;
            rstart_stb <= 1'b0;
        end else begin
            cmd_stb    <= 1'b0;
            lo_stb     <= 1'b0;
            hi_stb     <= 1'b0;
            quick_stb  <= 1'b0;
            stop_stb   <= 1'b0;
            rstart_stb <= 1'b0;
            if (start_det) begin
                state      <= ST_ADDR;
                bit_cnt    <= '0;
                in_ack     <= 1'b0;
                sda_oe     <= 1'b0;
                rstart_stb <= bus_active;
                bus_active <= 1'b1;
            end else if (stop_det) begin
                state      <= ST_IDLE;
                in_ack     <= 1'b0;
                sda_oe     <= 1'b0;
                stop_stb   <= 1'b1;
                bus_active <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise && !in_ack && (bit_cnt < CNT_FULL)) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + CNT_ONE;
                end else if (scl_fall && !in_ack && (bit_cnt == CNT_FULL)) begin
                    if (accept) begin
                        in_ack <= 1'b1;
                        sda_oe <= 1'b1;
                    end else begin
                        state  <= ST_IDLE;
                    end
                end else if (scl_rise && in_ack) begin
                    unique case (state)
                        ST_ADDR: begin
                            if (is_quick) begin
                                quick_stb  <= 1'b1;
                                quick_flag <= shreg[0];
                            end
                        end
                        ST_CMD: begin
                            cmd_stb <= 1'b1;
                            cmd_q   <= shreg;
                        end
                        ST_LO: lo_hold <= shreg;
                        ST_HI: begin
                            lo_stb <= 1'b1;
                            hi_stb <= 1'b1;
                            lo_q   <= lo_hold;
                            hi_q   <= shreg;
                        end
                        default: ;
                    endcase
                end else if (scl_fall && in_ack) begin
                    in_ack  <= 1'b0;
                    sda_oe  <= 1'b0;
                    bit_cnt <= '0;
                    state   <= next_st;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_wr_slave.sv
// Module: top of the write-only two-wire receiver.
// Assumes: clk is at least 10x the SCL rate; sda_oe drives an external
// open-drain pad (1 = pull low).
module i2c_wr_slave #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_HI_W   = 4,
    parameter int unsigned SEL_W       = 3,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI = 4'b0100,
    parameter logic [ADDR_HI_W+SEL_W-1:0] QUICK_ADDR = 7'b1111110
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [SEL_W-1:0] addr_sel,
    output logic             sda_oe,
    output logic             cmd_stb,
    output logic [7:0]       cmd_q,
    output logic             lo_stb,
    output logic [7:0]       lo_q,
    output logic             hi_stb,
    output logic [7:0]       hi_q,
    output logic             quick_stb,
    output logic             quick_flag,
    output logic             stop_stb,
    output logic             rstart_stb
);
    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {sda_i, scl_i};

    // One synchroniser per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (sync_lines[g])
        );
    end

    assign scl_s = sync_lines[0];
    assign sda_s = sync_lines[1];

    i2c_cond_detect u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_frame_fsm #(
        .ADDR_HI_W (ADDR_HI_W),
        .SEL_W     (SEL_W),
        .ADDR_HI   (ADDR_HI),
        .QUICK_ADDR(QUICK_ADDR)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_oe    (sda_oe),
        .cmd_stb   (cmd_stb),
        .cmd_q     (cmd_q),
        .lo_stb    (lo_stb),
        .lo_q      (lo_q),
        .hi_stb    (hi_stb),
        .hi_q      (hi_q),
        .quick_stb (quick_stb),
        .quick_flag(quick_flag),
        .stop_stb  (stop_stb),
        .rstart_stb(rstart_stb)
    );
endmodule

// File: rtl/i2c_wr_slave_chk.sv
// Module: protocol checker bound to the receiver top.
// Assumes: sampled on clk; disabled while rst_n is low.
module i2c_wr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic cmd_stb,
    input logic hi_stb,
    input logic quick_stb,
    input logic stop_stb,
    input logic rstart_stb
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sda_oe && !cmd_stb && !hi_stb && !stop_stb));

    // R2
    oe_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |-> !sda_oe);

    // R10
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    // R10
    hi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_stb |=> !hi_stb);

    // R10
    quick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quick_stb |=> !quick_stb);

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, hi_stb, quick_stb, stop_stb, rstart_stb}));
endmodule

bind i2c_wr_slave i2c_wr_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .cmd_stb   (cmd_stb),
    .hi_stb    (hi_stb),
    .quick_stb (quick_stb),
    .stop_stb  (stop_stb),
    .rstart_stb(rstart_stb)
);

// File: tb/test_i2c_wr_slave.sv
// Bench: drives bus transfers as a master and checks acks and strobes
// against a model written from the requirements.
module test_i2c_wr_slave;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] addr_sel = 3'd5;
    logic sda_oe, cmd_stb, lo_stb, hi_stb, quick_stb, quick_flag, stop_stb, rstart_stb;
    logic [7:0] cmd_q, lo_q, hi_q;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_wr_slave i_i2c_wr_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .addr_sel(addr_sel), .sda_oe(sda_oe),
        .cmd_stb(cmd_stb), .cmd_q(cmd_q), .lo_stb(lo_stb), .lo_q(lo_q),
        .hi_stb(hi_stb), .hi_q(hi_q), .quick_stb(quick_stb),
        .quick_flag(quick_flag), .stop_stb(stop_stb), .rstart_stb(rstart_stb)
    );

    int checks = 0;
    int errors = 0;
    int n_cmd = 0, n_lo = 0, n_hi = 0, n_quick = 0, n_stop = 0, n_rs = 0;
    int n_pair_bad = 0;
    logic [7:0] last_cmd = '0, last_lo = '0, last_hi = '0;
    logic last_flag = 1'b0;
    bit open_bus = 0;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_stb) begin n_cmd++; last_cmd = cmd_q; end
            if (lo_stb) begin n_lo++; last_lo = lo_q; end
            if (hi_stb) begin n_hi++; last_hi = hi_q; end
            if (lo_stb != hi_stb) n_pair_bad++;
            if (quick_stb) begin n_quick++; last_flag = quick_flag; end
            if (stop_stb) n_stop++;
            if (rstart_stb) n_rs++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic bit f_own_w(input logic [7:0] a, input logic [2:0] s);
        return (a[7:1] == {4'b0100, s}) && !a[0];
    endfunction

    function automatic bit f_quick(input logic [7:0] a);
        return a[7:1] == 7'b1111110;
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; wc(Q/2);
        scl_m = 1'b1; wc(Q);
        sda_m = 1'b0; wc(Q);
        scl_m = 1'b0; wc(Q/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wc(Q/2);
        scl_m = 1'b1; wc(Q);
        sda_m = 1'b1; wc(Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int nb);
        for (int i = 0; i < nb; i++) begin
            sda_m = v[7-i]; wc(Q/2);
            scl_m = 1'b1;   wc(Q);
            scl_m = 1'b0;   wc(Q/2);
        end
    endtask

    // Sends one byte and its acknowledge clock; a1/a2 = ack early/late in high phase.
    task automatic send_byte(input logic [7:0] v, output bit a1, output bit a2);
        send_bits(v, 8);
        sda_m = 1'b1; wc(Q/2);
        scl_m = 1'b1; wc(Q/4);
        @(negedge clk); a1 = !sda_bus;
        wc(Q/2);
        @(negedge clk); a2 = !sda_bus;
        wc(Q/4);
        scl_m = 1'b0; wc(Q/2);
    endtask

    // Full transfer with model-based expectations.
    task automatic xfer(input logic [7:0] ab, input int n, input logic [31:0] d, input bit end_stop);
        int c0 = n_cmd, l0 = n_lo, h0 = n_hi, q0 = n_quick, s0 = n_stop, r0 = n_rs;
        bit a1, a2, exp_ack;
        bit own_w = f_own_w(ab, addr_sel);
        bit quick = f_quick(ab);
        bus_start();
        chk("R9 repeated start strobe count", n_rs - r0, int'(open_bus));
        open_bus = 1;
        send_byte(ab, a1, a2);
        exp_ack = own_w || quick;
        chk(own_w ? "R3 own address ack" : (quick ? "R7 broadcast ack" : "R3 R8 address nack"),
            int'(a1 && a2), int'(exp_ack));
        chk("R2 ack held through high phase", int'(a1 == a2), 1);
        for (int i = 0; i < n; i++) begin
            exp_ack = own_w && (i < 3);
            send_byte(d[8*i +: 8], a1, a2);
            chk(i < 3 ? "R4 R5 data byte ack" : "R8 extra byte nack", int'(a1 || a2), int'(exp_ack));
        end
        if (end_stop) begin
            bus_stop();
            open_bus = 0;
        end
        wc(4);
        if (end_stop) chk("R9 stop strobe count", n_stop - s0, 1);
        chk("R4 R6 command strobe count", n_cmd - c0, int'(own_w && n >= 1));
        if (own_w && n >= 1) chk("R4 command value", int'(last_cmd), int'(d[7:0]));
        chk("R5 R6 low strobe count", n_lo - l0, int'(own_w && n >= 3));
        chk("R5 R6 high strobe count", n_hi - h0, int'(own_w && n >= 3));
        if (own_w && n >= 3) begin
            chk("R5 low value", int'(last_lo), int'(d[15:8]));
            chk("R5 high value", int'(last_hi), int'(d[23:16]));
        end
        chk("R7 quick strobe count", n_quick - q0, int'(quick));
        if (quick) chk("R7 quick flag", int'(last_flag), int'(ab[0]));
    endtask

    initial begin
        int c0;
        bit a1, a2;
        void'($urandom(32'h00C0FFEE));
        wc(10);
        // R1: reset state
        chk("R1 sda_oe in reset", int'(sda_oe), 0);
        chk("R1 strobes in reset", int'({cmd_stb, lo_stb, hi_stb, quick_stb, stop_stb, rstart_stb}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", int'({cmd_q, lo_q, hi_q, quick_flag, sda_oe}), 0);
        wc(20);

        // Full write, command only, cut after low byte then repeated start
        xfer({4'b0100, 3'd5, 1'b0}, 3, 32'h00_A3_5C_17, 1'b1);
        xfer({4'b0100, 3'd5, 1'b0}, 1, 32'h0000_00E2, 1'b1);
        xfer({4'b0100, 3'd5, 1'b0}, 2, 32'h0000_9966, 1'b0);
        xfer({4'b0100, 3'd5, 1'b0}, 3, 32'h00_03_FF_40, 1'b1);

        // R6: STOP in the middle of the command byte
        c0 = n_cmd;
        bus_start();
        send_byte({4'b0100, 3'd5, 1'b0}, a1, a2);
        send_bits(8'hC5, 4);
        bus_stop();
        wc(4);
        chk("R6 cut command not delivered", n_cmd - c0, 0);

        // Foreign address, read to own address, broadcast, overlong
        xfer({4'b0101, 3'd5, 1'b0}, 2, 32'h0000_1234, 1'b1);
        xfer({4'b0100, 3'd5, 1'b1}, 1, 32'h0000_0055, 1'b1);
        xfer(8'b1111_1101, 1, 32'h0000_00AA, 1'b1);
        xfer(8'b1111_1100, 0, 32'h0, 1'b1);
        xfer({4'b0100, 3'd5, 1'b0}, 4, 32'h77_21_08_3C, 1'b1);
        addr_sel = 3'd2;
        xfer({4'b0100, 3'd5, 1'b0}, 1, 32'h0000_0011, 1'b1);
        xfer({4'b0100, 3'd2, 1'b0}, 3, 32'h00_01_02_03, 1'b1);

        // Random transfers
        for (int k = 0; k < 30; k++) begin
            logic [7:0] ab;
            int kind = int'($urandom % 4);
            addr_sel = 3'($urandom % 8);
            case (kind)
                0, 1: ab = {4'b0100, addr_sel, 1'($urandom % 4 == 0)};
                2:    ab = {7'b1111110, 1'($urandom % 2)};
                default: ab = 8'($urandom);
            endcase
            xfer(ab, int'($urandom % 5), $urandom, bit'($urandom % 2));
        end
        if (open_bus) begin bus_stop(); open_bus = 0; wc(4); end

        // R5: low and high strobes always paired
        chk("R5 low/high strobe pairing", n_pair_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule